// File: doc/BRIEF.md
# Double-Buffered Gamma and VCOM Code Registers

This block holds the digital codes for nine 10-bit reference DAC channels: eight gamma taps and one common-electrode (VCOM) channel. Every channel has two register stages. The input stage takes writes. The output stage drives the DAC code buses. Software can preload new codes into the input stage while the panel keeps showing the old ones. A single write with the load flag set then moves every input code to the outputs on the same clock edge, so all nine reference voltages switch together.

The VCOM channel has a programmable ceiling and floor. They are applied only when a code moves into the output stage. The input stage always keeps the raw programmed value, and that raw value is the one a non-volatile store would save. If the ceiling is set below the floor, both limits are ignored.

A recall port models a load from non-volatile storage. It writes one channel's input and output stages in the same clock, or it writes one limit register. The write port is a valid/ready stream. Recall takes priority over writes: while `rcl_valid` is high, `wr_ready` is low and the write waits. A write is accepted only in a cycle where `wr_valid` and `wr_ready` are both high. Readback is a plain combinational lookup.

Top module: `gamma_dac_regfile`

## Requirements
- R1: After `rst_n` is low, or after a clock edge with `gc_reset` high, the following hold: all nine input and output codes are 0x200, the ceiling is 0x3FF and the floor is 0x000.
- R2: A write takes effect only when `wr_valid` and `wr_ready` are both high. `wr_ready` is low in any cycle where `rcl_valid` is high, and a write offered in such a cycle changes nothing.
- R3: Address map:
  - 0x00 to 0x07 are gamma channels 0 to 7.
  - 0x12 is VCOM.
  - 0x1E is the VCOM ceiling.
  - 0x1F is the VCOM floor.
  - Write data bits 9:0 carry the code. Bits 14:10 are ignored.
- R4: An accepted write with data bit 15 equal to 0 changes only the input stage. All output codes hold their values.
- R5: An accepted write with data bit 15 equal to 1 first applies the write. On the same clock edge, all nine outputs then load from the input stage, including the value just written. The result is visible the cycle after acceptance.
- R6: When VCOM loads into its output, the result depends on the ceiling and floor in force after that edge:
  - a code above the ceiling gives the ceiling;
  - a code below the floor gives the floor;
  - any other code passes unchanged.
- R7: When the ceiling is below the floor, the VCOM code passes to the output unclamped.
- R8: The VCOM input stage stores the raw code. A later load under wider limits therefore delivers the raw value.
- R9: Readback on `rd_data`, zero-extended to 16 bits:
  - a gamma address returns that channel's input code;
  - 0x12 returns the VCOM input code clamped by the current limits;
  - 0x1E and 0x1F return the ceiling and the floor;
  - every other address returns 0.
- R10: Recall to a channel address sets that channel's input code and its output code in one clock. The VCOM output is clamped as in R6 and R7. Other outputs hold. Recall to 0x1E or 0x1F sets that limit.
- R11: A write to an unmapped address stores nothing. If bit 15 is set, it still triggers the load of all outputs.
- R12: Output channel k sits on `out_codes[10k+9:10k]`. VCOM is k = 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gc_reset | input | 1 | Synchronous reset to defaults |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write can be accepted (low during recall) |
| wr_addr | input | 6 | Write address |
| wr_data | input | 16 | Write data: bit 15 load flag, bits 9:0 code |
| rcl_valid | input | 1 | Recall load strobe |
| rcl_addr | input | 6 | Recall address |
| rcl_code | input | 10 | Recalled code |
| rd_addr | input | 6 | Readback address |
| rd_data | output | 16 | Readback data |
| out_codes | output | 90 | Nine output codes, channel k at bits 10k+9:10k |

## Verification
The assertions take for granted that `gc_reset` is not asserted in the cycle they test. They also treat recall and write as exclusive only through `wr_ready`, so the checker never assumes that a blocked write has been accepted. The stimulus asserts recall and write together on purpose to exercise blocking. It draws addresses mostly from the mapped set, with some unmapped ones mixed in. It draws codes and limits, including inverted limit pairs, so that clamping above, below and inside the limits all occur. Directed cases cover reset defaults, limit bypass, raw-value retention and unmapped accesses.

// File: rtl/gdr_pkg.sv
package gdr_pkg;
  localparam int NCH = 9;
  localparam int CW  = 10;
  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int LOAD_BIT = 15;
  localparam logic [AW-1:0] VCOM_ADDR = 6'h12;
  localparam logic [AW-1:0] HI_ADDR   = 6'h1E;
  localparam logic [AW-1:0] LO_ADDR   = 6'h1F;
  localparam logic [CW-1:0] CODE_MID  = 10'h200;
  localparam logic [CW-1:0] HI_RESET  = 10'h3FF;
  localparam logic [CW-1:0] LO_RESET  = 10'h000;

  // channel k decodes at address k, except the last channel (VCOM)
  function automatic logic [AW-1:0] chan_addr(input int k);
    return (k == NCH-1) ? VCOM_ADDR : AW'(k);
  endfunction
endpackage

// File: rtl/gdr_vcom_limiter.sv
module gdr_vcom_limiter #(
  parameter int CW = 10
) (
  input  logic [CW-1:0] code,
  input  logic [CW-1:0] hi,
  input  logic [CW-1:0] lo,
  output logic [CW-1:0] limited
);
  logic bypass;
  always_comb begin
    bypass = (hi < lo);
    if (bypass)         limited = code;
    else if (code > hi) limited = hi;
    else if (code < lo) limited = lo;
    else                limited = code;
  end
endmodule

// File: rtl/gdr_input_stage.sv
module gdr_input_stage
  import gdr_pkg::*;
#(
  parameter int N  = NCH,
  parameter int W  = CW,
  parameter int A  = AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gc_reset,
  input  logic                wr_fire,
  input  logic [A-1:0]        wr_addr,
  input  logic [W-1:0]        wr_code,
  input  logic                rcl_fire,
  input  logic [A-1:0]        rcl_addr,
  input  logic [W-1:0]        rcl_code,
  output logic [N-1:0][W-1:0] cur_in,
  output logic [N-1:0][W-1:0] nxt_in,
  output logic [W-1:0]        cur_hi,
  output logic [W-1:0]        cur_lo,
  output logic [W-1:0]        nxt_hi,
  output logic [W-1:0]        nxt_lo,
  output logic [N-1:0]        rcl_hit
);
  logic         upd_en;
  logic [A-1:0] upd_addr;
  logic [W-1:0] upd_code;

  // recall has priority; the top never fires both
  always_comb begin
    upd_en   = rcl_fire | wr_fire;
    upd_addr = rcl_fire ? rcl_addr : wr_addr;
    upd_code = rcl_fire ? rcl_code : wr_code;
  end

  for (genvar k = 0; k < N; k++) begin : g_chan
    localparam logic [A-1:0] MY_ADDR = chan_addr(k);
    always_comb begin
      nxt_in[k]  = (upd_en && upd_addr == MY_ADDR) ? upd_code : cur_in[k];
      rcl_hit[k] = rcl_fire && (rcl_addr == MY_ADDR);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cur_in[k] <= CODE_MID;
      else if (gc_reset) cur_in[k] <= CODE_MID;
      else               cur_in[k] <= nxt_in[k];
    end
  end

  always_comb begin
    nxt_hi = (upd_en && upd_addr == HI_ADDR) ? upd_code : cur_hi;
    nxt_lo = (upd_en && upd_addr == LO_ADDR) ? upd_code : cur_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_hi <= HI_RESET;
      cur_lo <= LO_RESET;
    end else if (gc_reset) begin
      cur_hi <= HI_RESET;
      cur_lo <= LO_RESET;
    end else begin
      cur_hi <= nxt_hi;
      cur_lo <= nxt_lo;
    end
  end
endmodule

// File: rtl/gdr_output_stage.sv
module gdr_output_stage
  import gdr_pkg::*;
#(
  parameter int N = NCH,
  parameter int W = CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gc_reset,
  input  logic                load_all,
  input  logic [N-1:0]        load_one,
  input  logic [N-1:0][W-1:0] src,
  output logic [N-1:0][W-1:0] out_q
);
  for (genvar k = 0; k < N; k++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       out_q[k] <= CODE_MID;
      else if (gc_reset)                out_q[k] <= CODE_MID;
      else if (load_all || load_one[k]) out_q[k] <= src[k];
    end
  end
endmodule

// File: rtl/gamma_dac_regfile.sv
module gamma_dac_regfile
  import gdr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gc_reset,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               rcl_valid,
  input  logic [AW-1:0]      rcl_addr,
  input  logic [CW-1:0]      rcl_code,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic [NCH*CW-1:0]  out_codes
);
  localparam int VC = NCH - 1;

  logic                    wr_fire;
  logic                    load_all;
  logic [NCH-1:0][CW-1:0]  cur_in;
  logic [NCH-1:0][CW-1:0]  nxt_in;
  logic [CW-1:0]           cur_hi, cur_lo, nxt_hi, nxt_lo;
  logic [NCH-1:0]          rcl_hit;
  logic [CW-1:0]           vcom_load, vcom_view;
  logic [NCH-1:0][CW-1:0]  src;
  logic [NCH-1:0][CW-1:0]  out_q;

  always_comb begin
    wr_ready = ~rcl_valid;
    wr_fire  = wr_valid & wr_ready;
    load_all = wr_fire & wr_data[LOAD_BIT];
  end

  gdr_input_stage #(.N(NCH), .W(CW), .A(AW)) u_in (
    .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_code(wr_data[CW-1:0]),
    .rcl_fire(rcl_valid), .rcl_addr(rcl_addr), .rcl_code(rcl_code),
    .cur_in(cur_in), .nxt_in(nxt_in),
    .cur_hi(cur_hi), .cur_lo(cur_lo), .nxt_hi(nxt_hi), .nxt_lo(nxt_lo),
    .rcl_hit(rcl_hit)
  );

  // clamp for the value entering the output stage (post-edge limits)
  gdr_vcom_limiter #(.CW(CW)) u_lim_load (
    .code(nxt_in[VC]), .hi(nxt_hi), .lo(nxt_lo), .limited(vcom_load)
  );

  // clamp for readback of the stored VCOM code (current limits)
  gdr_vcom_limiter #(.CW(CW)) u_lim_view (
    .code(cur_in[VC]), .hi(cur_hi), .lo(cur_lo), .limited(vcom_view)
  );

  always_comb begin
    for (int k = 0; k < VC; k++) src[k] = nxt_in[k];
    src[VC] = vcom_load;
  end

  gdr_output_stage #(.N(NCH), .W(CW)) u_out (
    .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset),
    .load_all(load_all), .load_one(rcl_hit), .src(src), .out_q(out_q)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_flat
    assign out_codes[k*CW +: CW] = out_q[k];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < VC; k++)
      if (rd_addr == chan_addr(k)) rd_data = DW'(cur_in[k]);
    if (rd_addr == VCOM_ADDR) rd_data = DW'(vcom_view);
    if (rd_addr == HI_ADDR)   rd_data = DW'(cur_hi);
    if (rd_addr == LO_ADDR)   rd_data = DW'(cur_lo);
  end
endmodule

// File: rtl/gdr_checker.sv
module gdr_checker
  import gdr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              gc_reset,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [AW-1:0]     wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              rcl_valid,
  input logic [AW-1:0]     rcl_addr,
  input logic [CW-1:0]     rcl_code,
  input logic [NCH*CW-1:0] out_codes,
  input logic [CW-1:0]     lim_hi,
  input logic [CW-1:0]     lim_lo
);
  logic [CW-1:0] vcom_out;
  assign vcom_out = out_codes[(NCH-1)*CW +: CW];

  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> (out_codes == {NCH{CODE_MID}}) && lim_hi == HI_RESET && lim_lo == LO_RESET);

  assert_hold_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !wr_data[LOAD_BIT] && !rcl_valid && !gc_reset)
      |=> $stable(out_codes));

  assert_load_gamma_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && wr_data[LOAD_BIT] && wr_addr < AW'(NCH-1) && !gc_reset)
      |=> out_codes[$past(wr_addr[3:0])*CW +: CW] == $past(wr_data[CW-1:0]));

  // R6 and R7: a fresh VCOM output lies within the limits unless they are inverted
  assert_vcom_in_limits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(vcom_out) && !$past(gc_reset))
      |-> (lim_hi < lim_lo) || (vcom_out <= lim_hi && vcom_out >= lim_lo));

  assert_recall_gamma_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rcl_valid && rcl_addr < AW'(NCH-1) && !gc_reset)
      |=> out_codes[$past(rcl_addr[3:0])*CW +: CW] == $past(rcl_code));
endmodule

bind gamma_dac_regfile gdr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
  .rcl_valid(rcl_valid), .rcl_addr(rcl_addr), .rcl_code(rcl_code),
  .out_codes(out_codes), .lim_hi(cur_hi), .lim_lo(cur_lo)
);

// File: tb/sim_gamma_dac_regfile.sv
module sim_gamma_dac_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int N = 9;

  logic        clk = 0, rst_n = 0, gc_reset = 0;
  logic        wr_valid = 0, rcl_valid = 0;
  logic        wr_ready;
  logic [5:0]  wr_addr = 0, rcl_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic [9:0]  rcl_code = 0;
  logic [89:0] out_codes;

  int checks = 0, errors = 0;
  logic [9:0] m_in [N];
  logic [9:0] m_out[N];
  logic [9:0] m_hi, m_lo;

  always #(CLK_PERIOD/2) clk = ~clk;

  gamma_dac_regfile u0 (
    .clk(clk), .rst_n(rst_n), .gc_reset(gc_reset),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rcl_valid(rcl_valid), .rcl_addr(rcl_addr), .rcl_code(rcl_code),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_codes(out_codes)
  );

  function automatic logic [9:0] clampf(logic [9:0] v, logic [9:0] hi, logic [9:0] lo);
    if (hi < lo) return v;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic int chan_of(logic [5:0] a);
    if (a < 6'd8) return int'(a);
    if (a == 6'h12) return 8;
    return -1;
  endfunction

  function automatic logic [15:0] model_rd(logic [5:0] a);
    int c = chan_of(a);
    if (c == 8) return {6'b0, clampf(m_in[8], m_hi, m_lo)};
    if (c >= 0) return {6'b0, m_in[c]};
    if (a == 6'h1E) return {6'b0, m_hi};
    if (a == 6'h1F) return {6'b0, m_lo};
    return 16'h0;
  endfunction

  function automatic logic [89:0] model_outs();
    logic [89:0] v;
    for (int k = 0; k < N; k++) v[k*10 +: 10] = m_out[k];
    return v;
  endfunction

  task automatic model_defaults();
    for (int k = 0; k < N; k++) begin m_in[k] = 10'h200; m_out[k] = 10'h200; end
    m_hi = 10'h3FF; m_lo = 10'h000;
  endtask

  task automatic model_store(logic [5:0] a, logic [9:0] c);
    int ch = chan_of(a);
    if (ch >= 0) m_in[ch] = c;
    else if (a == 6'h1E) m_hi = c;
    else if (a == 6'h1F) m_lo = c;
  endtask

  task automatic check_outs(string req);
    logic [89:0] exp = model_outs();
    checks++;
    if (out_codes !== exp) begin
      errors++;
      $display("FAIL %s out_codes act=%h exp=%h", req, out_codes, exp);
    end
  endtask

  task automatic check_rd(logic [5:0] a, string req);
    logic [15:0] exp = model_rd(a);
    rd_addr = a; #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s rd[%h] act=%h exp=%h", req, a, rd_data, exp);
    end
  endtask

  task automatic do_write(logic [5:0] a, logic [15:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
    model_store(a, d[9:0]);
    if (d[15]) begin
      for (int k = 0; k < 8; k++) m_out[k] = m_in[k];
      m_out[8] = clampf(m_in[8], m_hi, m_lo);
    end
  endtask

  task automatic do_recall(logic [5:0] a, logic [9:0] c, bit with_write);
    int ch = chan_of(a);
    @(negedge clk);
    rcl_valid = 1; rcl_addr = a; rcl_code = c;
    if (with_write) begin
      wr_valid = 1; wr_addr = 6'h00; wr_data = 16'h8000 | 16'h0155;
      #1; checks++;
      if (wr_ready !== 1'b0) begin
        errors++; $display("FAIL R2 wr_ready act=%b exp=0", wr_ready);
      end
    end
    @(negedge clk);
    rcl_valid = 0; wr_valid = 0;
    model_store(a, c);
    if (ch == 8) m_out[8] = clampf(c, m_hi, m_lo);
    else if (ch >= 0) m_out[ch] = c;
  endtask

  logic [5:0] addr_pool [12] = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07,
                                 6'h12, 6'h1E, 6'h1F, 6'h0A};

  bit done = 0;

  initial begin
    int wd = 0;
    while (!done && wd < 150000) begin @(posedge clk); wd++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<150000", wd);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    model_defaults();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check_outs("R1");
    check_rd(6'h1E, "R1"); check_rd(6'h1F, "R1"); check_rd(6'h12, "R1");

    // R4: preload without flag, outputs held; R3 upper bits ignored
    do_write(6'h03, 16'h7C00 | 16'h0123);
    check_outs("R4"); check_rd(6'h03, "R3");
    // R5: flagged write loads all
    do_write(6'h05, 16'h8000 | 16'h0042);
    check_outs("R5");
    // R6 clamp above ceiling and below floor
    do_write(6'h1E, 16'h0300); do_write(6'h1F, 16'h0100);
    do_write(6'h12, 16'h83F0); check_outs("R6"); check_rd(6'h12, "R9");
    do_write(6'h12, 16'h8010); check_outs("R6"); check_rd(6'h12, "R9");
    // R8 raw value kept: widen limits then load
    do_write(6'h1F, 16'h0000); do_write(6'h1E, 16'h83FF);
    check_outs("R8"); check_rd(6'h12, "R8");
    // R7 inverted limits bypass
    do_write(6'h1E, 16'h0050); do_write(6'h1F, 16'h0200);
    do_write(6'h12, 16'h8300); check_outs("R7"); check_rd(6'h12, "R7");
    // R11 unmapped write stores nothing but still loads
    do_write(6'h02, 16'h0077);
    do_write(6'h0B, 16'h8111); check_outs("R11"); check_rd(6'h0B, "R11");
    check_rd(6'h3C, "R9");
    // R10 recall, R2 blocking
    do_recall(6'h06, 10'h2AA, 1'b1); check_outs("R10"); check_rd(6'h00, "R2");
    do_recall(6'h12, 10'h3FE, 1'b0); check_outs("R10"); check_rd(6'h12, "R10");
    do_recall(6'h1F, 10'h011, 1'b0); check_rd(6'h1F, "R10");
    // R12 field position for channel 7
    do_write(6'h07, 16'h8000 | 16'h0ABC & 16'h83FF);
    checks++;
    if (out_codes[79:70] !== m_in[7]) begin
      errors++; $display("FAIL R12 ch7 act=%h exp=%h", out_codes[79:70], m_in[7]);
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 9);
      logic [5:0] a = addr_pool[$urandom_range(0, 11)];
      logic [9:0] c = 10'($urandom);
      if (sel < 7) begin
        logic [15:0] d = {1'($urandom_range(0, 1)), 5'($urandom), c};
        do_write(a, d);
        check_outs(d[15] ? "R5" : "R4");
      end else begin
        do_recall(a, c, 1'($urandom_range(0, 1)));
        check_outs("R10");
      end
      check_rd(addr_pool[$urandom_range(0, 11)], "R9");
      check_rd(6'h12, "R6");
    end

    // R1 general-call reset
    @(negedge clk); gc_reset = 1; @(negedge clk); gc_reset = 0;
    model_defaults();
    check_outs("R1"); check_rd(6'h04, "R1"); check_rd(6'h1E, "R1");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule